// File: doc/BRIEF.md
# Link Controller Interrupt Status Register

This block holds the interrupt status word of a memory-link controller. Internal sources pulse one-cycle event strobes: correctable and uncorrectable ECC events from the response queue and from the retry buffer, and a token-exhaustion strobe from the flow-control logic. The external memory device also signals a fatal condition on an active-low pin. Each event sets its own sticky bit in a 32-bit word. Software reads that word at offset 0x20 of a simple register bus and clears bits by writing ones to them.

A single interrupt line goes high while any status bit is set, provided the global enable input is high. Token-exhaustion reporting is disarmed after reset. It is armed by the first token-return strobe after the link comes up, so the start-up period, when the device has not yet advertised its buffer space, does not raise false alarms. A build-time switch removes ECC reporting completely.

Top module: `irq_status_reg`

## Requirements
- R1: After reset every status bit is 0, `irqOut` is 0 and a read of offset 0x20 returns 0.
- R2: With ECC reporting built in, a pulse on `evRqUncorr` sets bit 15 and a pulse on `evRqCorr` sets bit 14, both visible on the first clock edge after the pulse.
- R3: With ECC reporting built in, a pulse on `evRbUncorr` sets bit 12 and a pulse on `evRbCorr` sets bit 11, both visible on the first clock edge after the pulse.
- R4: `fatalPinN` passes through a two-flop synchronizer. A low level on the pin sets bit 13 on the third rising edge after the pin goes low, and it keeps setting bit 13 for as long as the pin stays low.
- R5: A pulse on `evTokenEmpty` sets bit 9 only after a `evFirstTokenRet` pulse has been registered. Earlier pulses, including one in the same cycle as the arming pulse, are ignored.
- R6: A write to offset 0x20 clears each status bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged. A write to any other offset changes nothing.
- R7: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: Bits 31:16, bit 10 and bits 8:0 always read 0 and ignore writes.
- R9: `irqOut` is 1 exactly when `irqEnable` is 1 and at least one status bit is set.
- R10: When `ECC_EN` is 0, bits 15, 14, 12 and 11 stay 0 whatever the ECC strobes do.
- R11: `regRdData` is registered. It shows the status word one cycle after a read strobe at offset 0x20, and it is 0 in every other cycle and for reads at other offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Write data; a 1 clears the matching status bit |
| regRdData | output | 32 | Registered read data |
| evRqUncorr | input | 1 | Response-queue uncorrectable ECC event strobe |
| evRqCorr | input | 1 | Response-queue correctable ECC event strobe |
| evRbUncorr | input | 1 | Retry-buffer uncorrectable ECC event strobe |
| evRbCorr | input | 1 | Retry-buffer correctable ECC event strobe |
| evTokenEmpty | input | 1 | Transmit tokens exhausted strobe |
| evFirstTokenRet | input | 1 | Token-return strobe that arms token reporting |
| fatalPinN | input | 1 | Asynchronous active-low fatal-error pin from the device |
| irqEnable | input | 1 | Global interrupt enable |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench runs two copies of the block side by side, one with ECC reporting built in and one without. It drives the same single events, combined events, clears and pin activity into both, and a scoreboard compares the read-back words of each copy. Separate strobes on each source show that every source maps to its own bit. A clear with a partial mask, a clear with a zero mask and a clear at the wrong offset together show that a write clears exactly the bits given by ones at the right offset. Token pulses sent before and after arming show the freeze. A clear that lands in the same cycle as a set, and a clear issued while the fatal pin is still held low, show that a set wins over a clear. The bench also counts the edges from a pin fall to the interrupt, which pins down the synchronizer depth.

// File: rtl/isr_pkg.sv
package isr_pkg;

  localparam int STATUS_W = 32;

  localparam int BIT_RQ_UNCORR = 15;
  localparam int BIT_RQ_CORR   = 14;
  localparam int BIT_FATAL     = 13;
  localparam int BIT_RB_UNCORR = 12;
  localparam int BIT_RB_CORR   = 11;
  localparam int BIT_TOKEN     = 9;

  localparam logic [STATUS_W-1:0] DEFINED_MASK = STATUS_W'(
      (1 << BIT_RQ_UNCORR) | (1 << BIT_RQ_CORR) | (1 << BIT_FATAL) |
      (1 << BIT_RB_UNCORR) | (1 << BIT_RB_CORR) | (1 << BIT_TOKEN));

  localparam logic [STATUS_W-1:0] ECC_MASK = STATUS_W'(
      (1 << BIT_RQ_UNCORR) | (1 << BIT_RQ_CORR) |
      (1 << BIT_RB_UNCORR) | (1 << BIT_RB_CORR));

  typedef struct packed {
    logic                wrHit;
    logic                rdHit;
    logic [STATUS_W-1:0] clrMask;
  } isrStrobes_t;

endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned STATUS_ADDR = 32'h20
) (
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [STATUS_W-1:0] regWrData,
  output isrStrobes_t         strobes
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STATUS_ADDR);

  logic addrHit;

  always_comb begin
    addrHit         = (regAddr == HIT_ADDR);
    strobes.wrHit   = regWrEn && addrHit;
    strobes.rdHit   = regRdEn && addrHit;
    strobes.clrMask = strobes.wrHit ? (regWrData & DEFINED_MASK) : '0;
  end

endmodule

// File: rtl/isr_sync.sv
module isr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chainQ;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chainQ[s] <= RESET_VAL;
        end else if (s == 0) begin
          chainQ[s] <= asyncIn;
        end else begin
          chainQ[s] <= chainQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chainQ[STAGES-1];

endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
#(
  parameter bit ECC_EN      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  isrStrobes_t         strobes,
  input  logic                evRqUncorr,
  input  logic                evRqCorr,
  input  logic                evRbUncorr,
  input  logic                evRbCorr,
  input  logic                evTokenEmpty,
  input  logic                evFirstTokenRet,
  input  logic                fatalPinN,
  output logic [STATUS_W-1:0] statusQ,
  output logic [STATUS_W-1:0] rdDataQ
);

  logic                fatalSyncN;
  logic                tokenArmedQ;
  logic [STATUS_W-1:0] setVec;

  isr_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_fatalSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(fatalPinN),
    .syncOut(fatalSyncN)
  );

  // Token reporting stays frozen until the first token return is registered.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tokenArmedQ <= 1'b0;
    else       tokenArmedQ <= tokenArmedQ | evFirstTokenRet;
  end

  always_comb begin
    setVec                = '0;
    setVec[BIT_RQ_UNCORR] = ECC_EN && evRqUncorr;
    setVec[BIT_RQ_CORR]   = ECC_EN && evRqCorr;
    setVec[BIT_RB_UNCORR] = ECC_EN && evRbUncorr;
    setVec[BIT_RB_CORR]   = ECC_EN && evRbCorr;
    setVec[BIT_FATAL]     = !fatalSyncN;
    setVec[BIT_TOKEN]     = tokenArmedQ && evTokenEmpty;
  end

  generate
    for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
      if (DEFINED_MASK[i]) begin : g_live
        // A set in the same cycle as a clear wins.
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) statusQ[i] <= 1'b0;
          else       statusQ[i] <= setVec[i] | (statusQ[i] & ~strobes.clrMask[i]);
        end
      end else begin : g_rsvd
        assign statusQ[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdDataQ <= '0;
    else if (strobes.rdHit) rdDataQ <= statusQ;
    else                    rdDataQ <= '0;
  end

  // R7: every bit set by hardware is present after the edge, whatever the clear mask.
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(setVec)) == $past(setVec)));

  // R6: a cleared bit with no set in that cycle is 0 afterwards.
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(strobes.clrMask & ~setVec)) == '0));

  // R5: the token bit cannot be set before arming.
  p_token_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tokenArmedQ |-> !statusQ[BIT_TOKEN]);

  // R11: read data mirrors the status word of the read cycle.
  p_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.rdHit) |-> (rdDataQ == $past(statusQ)));

  // R11: read data is 0 outside a read response.
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.rdHit) |-> (rdDataQ == '0));

  generate
    if (!ECC_EN) begin : g_eccOff
      // R10: ECC bits stay clear when ECC reporting is not built in.
      p_ecc_off_r10: assert property (@(posedge clk) disable iff (!rstN)
        (statusQ & ECC_MASK) == '0);
    end
  endgenerate

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import isr_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned STATUS_ADDR = 32'h20,
  parameter bit          ECC_EN      = 1'b1,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              evRqUncorr,
  input  logic              evRqCorr,
  input  logic              evRbUncorr,
  input  logic              evRbCorr,
  input  logic              evTokenEmpty,
  input  logic              evFirstTokenRet,
  input  logic              fatalPinN,
  input  logic              irqEnable,
  output logic              irqOut
);

  isrStrobes_t         strobes;
  logic [STATUS_W-1:0] statusQ;

  isr_ctrl #(
    .ADDR_W     (ADDR_W),
    .STATUS_ADDR(STATUS_ADDR)
  ) u_ctrl (
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  isr_datapath #(
    .ECC_EN     (ECC_EN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .evRqUncorr     (evRqUncorr),
    .evRqCorr       (evRqCorr),
    .evRbUncorr     (evRbUncorr),
    .evRbCorr       (evRbCorr),
    .evTokenEmpty   (evTokenEmpty),
    .evFirstTokenRet(evFirstTokenRet),
    .fatalPinN      (fatalPinN),
    .statusQ        (statusQ),
    .rdDataQ        (regRdData)
  );

  assign irqOut = irqEnable && (statusQ != '0);

  // R9: an interrupt is only raised from a set status bit.
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0));

  // R8: reserved positions never show up on the read bus.
  p_rsvd_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~DEFINED_MASK) == '0);

endmodule

// File: tb/sim_irq_status_reg.sv
module sim_irq_status_reg;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp0;
    logic [31:0] exp1;
    string       tag;
  } rdItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = 32'h0;
  logic        evRqUncorr = 1'b0, evRqCorr = 1'b0, evRbUncorr = 1'b0, evRbCorr = 1'b0;
  logic        evTokenEmpty = 1'b0, evFirstTokenRet = 1'b0;
  logic        fatalPinN = 1'b1;
  logic        irqEnable = 1'b0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  int checks = 0;
  int errors = 0;
  rdItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_reg #(.ECC_EN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rd0), .evRqUncorr(evRqUncorr), .evRqCorr(evRqCorr),
    .evRbUncorr(evRbUncorr), .evRbCorr(evRbCorr), .evTokenEmpty(evTokenEmpty),
    .evFirstTokenRet(evFirstTokenRet), .fatalPinN(fatalPinN), .irqEnable(irqEnable),
    .irqOut(irq0));

  irq_status_reg #(.ECC_EN(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rd1), .evRqUncorr(evRqUncorr), .evRqCorr(evRqCorr),
    .evRbUncorr(evRbUncorr), .evRbCorr(evRbCorr), .evTokenEmpty(evTokenEmpty),
    .evFirstTokenRet(evFirstTokenRet), .fatalPinN(fatalPinN), .irqEnable(irqEnable),
    .irqOut(irq1));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readExpect(input logic [7:0] addr, input logic [31:0] e0, input logic [31:0] e1, input string tag);
    @(negedge clk);
    regRdEn = 1'b1;
    regAddr = addr;
    expQ.push_back('{exp0: e0, exp1: e1, tag: tag});
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = addr;
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = 32'h0;
  endtask

  // which = {rqUncorr, rqCorr, rbUncorr, rbCorr, tokenEmpty}
  task automatic pulse(input logic [4:0] which);
    @(negedge clk);
    {evRqUncorr, evRqCorr, evRbUncorr, evRbCorr, evTokenEmpty} = which;
    @(negedge clk);
    {evRqUncorr, evRqCorr, evRbUncorr, evRbCorr, evTokenEmpty} = 5'b0;
  endtask

  // Scoreboard monitor: pops one expected item per read strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (regRdEn) begin
        rdItem_t it;
        @(negedge clk);
        if (expQ.size() == 0) begin
          check(1'b0, "R11 unexpected read", rd0, 32'h0);
        end else begin
          it = expQ.pop_front();
          check(rd0 == it.exp0, {it.tag, " u0"}, rd0, it.exp0);
          check(rd1 == it.exp1, {it.tag, " u1"}, rd1, it.exp1);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(irq0 == 1'b0, "R1 irq after reset", {31'h0, irq0}, 32'h0);
    readExpect(8'h20, 32'h0, 32'h0, "R1 reset read");

    irqEnable = 1'b1;
    pulse(5'b10000);
    check(irq0 == 1'b1, "R9 irq with bit set", {31'h0, irq0}, 32'h1);
    check(irq1 == 1'b0, "R10 no irq without ecc", {31'h0, irq1}, 32'h0);
    readExpect(8'h20, 32'h8000, 32'h0, "R2 rq uncorrectable");
    pulse(5'b01000);
    readExpect(8'h20, 32'hC000, 32'h0, "R2 rq correctable");

    writeReg(8'h20, 32'h8000);
    readExpect(8'h20, 32'h4000, 32'h0, "R6 partial clear");
    writeReg(8'h20, 32'h0);
    readExpect(8'h20, 32'h4000, 32'h0, "R6 zero write");
    writeReg(8'h24, 32'hFFFF_FFFF);
    readExpect(8'h20, 32'h4000, 32'h0, "R6 wrong offset write");
    readExpect(8'h24, 32'h0, 32'h0, "R11 read other offset");
    writeReg(8'h20, 32'hFFFF_FFFF);
    readExpect(8'h20, 32'h0, 32'h0, "R8 full clear");
    check(irq0 == 1'b0, "R9 irq drops after clear", {31'h0, irq0}, 32'h0);

    pulse(5'b00110);
    readExpect(8'h20, 32'h1800, 32'h0, "R3 retry buffer both");
    writeReg(8'h20, 32'hFFFF_FFFF);

    pulse(5'b00001);
    readExpect(8'h20, 32'h0, 32'h0, "R5 token before arming");
    @(negedge clk);
    evFirstTokenRet = 1'b1;
    evTokenEmpty = 1'b1;
    @(negedge clk);
    evFirstTokenRet = 1'b0;
    evTokenEmpty = 1'b0;
    readExpect(8'h20, 32'h0, 32'h0, "R5 token same cycle as arming");
    pulse(5'b00001);
    readExpect(8'h20, 32'h200, 32'h200, "R5 token after arming");

    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = 8'h20;
    regWrData = 32'h200;
    evTokenEmpty = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = 32'h0;
    evTokenEmpty = 1'b0;
    readExpect(8'h20, 32'h200, 32'h200, "R7 set beats clear");
    writeReg(8'h20, 32'h200);
    readExpect(8'h20, 32'h0, 32'h0, "R6 token cleared");

    irqEnable = 1'b0;
    pulse(5'b10000);
    check(irq0 == 1'b0, "R9 irq gated off", {31'h0, irq0}, 32'h0);
    @(negedge clk);
    irqEnable = 1'b1;
    #1;
    check(irq0 == 1'b1, "R9 irq after enable", {31'h0, irq0}, 32'h1);
    check(irq1 == 1'b0, "R10 ecc-less stays quiet", {31'h0, irq1}, 32'h0);
    writeReg(8'h20, 32'hFFFF_FFFF);

    @(negedge clk);
    fatalPinN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(irq0 == 1'b0, "R4 not yet after two edges", {31'h0, irq0}, 32'h0);
    @(negedge clk);
    check(irq0 == 1'b1, "R4 set on third edge", {31'h0, irq0}, 32'h1);
    readExpect(8'h20, 32'h2000, 32'h2000, "R4 fatal bit");
    writeReg(8'h20, 32'h2000);
    readExpect(8'h20, 32'h2000, 32'h2000, "R4 R7 pin still low");
    fatalPinN = 1'b1;
    repeat (4) @(negedge clk);
    writeReg(8'h20, 32'h2000);
    readExpect(8'h20, 32'h0, 32'h0, "R4 cleared after release");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11 scoreboard drained", expQ.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule